// File: doc/BRIEF.md
# ECC Error Statistics Counters

This block gathers error events from the read path of a memory controller that serves two pseudo channels. A decoder raises a one-cycle pulse per channel for each correctable (single-bit) error and for each uncorrectable (double-bit) error. The block turns those pulses into saturating per-channel counts that software reads through a simple register port. It also raises a per-channel alert once correctable errors on that channel go past a programmable level.

The correctable counter on each channel is gated by a shared threshold. A hidden pre-count absorbs correctable errors until their number exceeds the threshold. Only then does the visible counter start to move and the alert start to fire. The alert stays up until software reads its register, and the read clears it. A global clear bit holds every counter and pre-count at zero for as long as it is set.

Each channel is steered by a small state machine with three states. HOLD is entered on any cycle the clear bit is 1. ARM is the state in which the pre-count gathers errors. COUNT is the state after the threshold has been exceeded. The transitions are:
- any state to HOLD while clear is set;
- HOLD to ARM once clear is 0 and no crossing error arrives;
- HOLD or ARM to COUNT on the correctable error that exceeds the threshold;
- ARM stays in ARM on other cycles, and COUNT stays in COUNT.

Top module: `ecc_err_stats`

## Requirements
- R1: Every error counter is 8 bits wide and saturates: once at 255 it holds 255 on further errors and never wraps.
- R2: While the clear bit (bit 0 of the control register at offset 0x00) is 1, all error counters and pre-counts are 0 and error pulses are ignored. After clear returns to 0, counting resumes from zero, and the pre-count starts over against the threshold.
- R3: The threshold register sits at offset 0x04, bits 7:0. A channel's correctable counter stays 0 until the number of correctable errors since reset or clear exceeds the threshold. The error that exceeds it is the first one counted, so with threshold N the counter reads k-N after k errors, for k > N.
- R4: The channel's alert flag (output thr_flag[ch], and bit 0 of its flag register) is set by each correctable error that arrives once the count exceeds the threshold.
- R5: A read of a channel's flag register returns the flag and clears it on that clock edge. If an exceeding error arrives in the same cycle as that read, the flag stays set.
- R6: Uncorrectable counters count from the first error and ignore the threshold.
- R7: Each channel ch has three registers at 0x08+12*ch: the correctable count at +0, the uncorrectable count at +4 and the flag at +8. Reads return zeros above the used bits. Unmapped offsets read 0. Writes to count and flag registers have no effect.
- R8: After reset, all counters, flags, the clear bit and the threshold are 0.
- R9: Events on one channel never change the other channel's registers or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_err | input | 2 | Per-channel correctable error pulse |
| ue_err | input | 2 | Per-channel uncorrectable error pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle reg_rd is high, 0 otherwise |
| thr_flag | output | 2 | Per-channel threshold alert |

## Verification
Two functions can act in the same cycle. One is the read that clears a flag; the other is a correctable error that sets it again. The bench raises a flag, then drives a read of that flag register and an error pulse on the same channel in one cycle. It expects the read to return 1 and the flag to still be 1 afterwards. A second read with no error must then clear it. The clear bit against incoming errors is handled the same way: pulses sent while clear is held must leave every count at zero.

// File: rtl/ecc_stats_pkg.sv
package ecc_stats_pkg;

    typedef enum logic [1:0] {
        TRK_ARM   = 2'd0,
        TRK_COUNT = 2'd1,
        TRK_HOLD  = 2'd2
    } trk_state_e;

    localparam int unsigned OFS_CTRL      = 0;
    localparam int unsigned OFS_THRESH    = 4;
    localparam int unsigned OFS_CH_BASE   = 8;
    localparam int unsigned OFS_CH_STRIDE = 12;
    localparam int unsigned SLOT_CE       = 0;
    localparam int unsigned SLOT_UE       = 4;
    localparam int unsigned SLOT_FLAG     = 8;

endpackage

// File: rtl/ecc_sat_counter.sv
module ecc_sat_counter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] q
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clr) begin
            q <= '0;
        end else if (inc && (q != CNT_MAX)) begin
            q <= q + 1'b1;
        end
    end

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (q == CNT_MAX && !clr) |=> (q == CNT_MAX)); // R1

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q == '0)); // R2

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !inc) |=> $stable(q)); // R1

endmodule

// File: rtl/ecc_chan_tracker.sv
module ecc_chan_tracker
    import ecc_stats_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [CNT_W-1:0] thresh,
    input  logic             ce_err,
    input  logic             ue_err,
    input  logic             flag_rd,
    output logic [CNT_W-1:0] ce_cnt,
    output logic [CNT_W-1:0] ue_cnt,
    output logic             flag
);
    trk_state_e       st_q;
    trk_state_e       st_d;
    logic [CNT_W-1:0] pre_q;
    logic             gathering;
    logic             exceed_evt;
    logic             pre_inc;

    // A channel gathers into the pre-count in every state except COUNT.
    assign gathering  = (st_q != TRK_COUNT);
    assign exceed_evt = ce_err && !clr && (!gathering || (pre_q >= thresh));
    assign pre_inc    = ce_err && !clr && gathering && (pre_q < thresh);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= TRK_ARM;
        end else begin
            st_q <= st_d;
        end
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = TRK_HOLD;
        end else begin
            unique case (st_q)
                TRK_HOLD:  st_d = exceed_evt ? TRK_COUNT : TRK_ARM;
                TRK_ARM:   st_d = exceed_evt ? TRK_COUNT : TRK_ARM;
                TRK_COUNT: st_d = TRK_COUNT;
                default:   st_d = TRK_ARM;
            endcase
        end
    end

    // Pre-count, below the threshold only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (clr) begin
            pre_q <= '0;
        end else if (pre_inc) begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // Alert flag: a new exceed event wins over a clearing read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (exceed_evt) begin
            flag <= 1'b1;
        end else if (flag_rd) begin
            flag <= 1'b0;
        end
    end

    ecc_sat_counter #(.CNT_W(CNT_W)) u_ce_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .inc   (exceed_evt),
        .q     (ce_cnt)
    );

    ecc_sat_counter #(.CNT_W(CNT_W)) u_ue_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .inc   (ue_err),
        .q     (ue_cnt)
    );

    AST_ARM_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TRK_ARM) |-> (ce_cnt == '0)); // R3

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_err && !clr && st_q == TRK_COUNT) |=> flag); // R5

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rd && !ce_err) |=> !flag); // R5

    AST_UE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ue_err && !clr && ue_cnt != {CNT_W{1'b1}}) |=> (ue_cnt == $past(ue_cnt) + 1'b1)); // R6

    AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (pre_q == '0 && st_q == TRK_HOLD)); // R2

endmodule

// File: rtl/ecc_reg_file.sv
module ecc_reg_file
    import ecc_stats_pkg::*;
#(
    parameter int unsigned NUM_CH = 2,
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_wr,
    input  logic                          reg_rd,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic [DATA_W-1:0]             reg_wdata,
    input  logic [NUM_CH-1:0][CNT_W-1:0]  ce_cnt,
    input  logic [NUM_CH-1:0][CNT_W-1:0]  ue_cnt,
    input  logic [NUM_CH-1:0]             flag,
    output logic                          clr,
    output logic [CNT_W-1:0]              thresh,
    output logic [NUM_CH-1:0]             flag_rd,
    output logic [DATA_W-1:0]             reg_rdata
);
    logic [DATA_W-1:0] ch_word [NUM_CH];
    logic [DATA_W-1:0] cfg_word;
    logic              hit_ctrl;
    logic              hit_thresh;

    assign hit_ctrl   = (reg_addr == ADDR_W'(OFS_CTRL));
    assign hit_thresh = (reg_addr == ADDR_W'(OFS_THRESH));

    // Control and threshold registers; all other offsets are read-only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr    <= 1'b0;
            thresh <= '0;
        end else if (reg_wr) begin
            if (hit_ctrl) begin
                clr <= reg_wdata[0];
            end
            if (hit_thresh) begin
                thresh <= reg_wdata[CNT_W-1:0];
            end
        end
    end

    always_comb begin
        cfg_word = '0;
        if (hit_ctrl) begin
            cfg_word[0] = clr;
        end else if (hit_thresh) begin
            cfg_word[CNT_W-1:0] = thresh;
        end
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        localparam int unsigned BASE = OFS_CH_BASE + ch * OFS_CH_STRIDE;
        logic [DATA_W-1:0] word;

        always_comb begin
            word = '0;
            if (reg_addr == ADDR_W'(BASE + SLOT_CE)) begin
                word[CNT_W-1:0] = ce_cnt[ch];
            end else if (reg_addr == ADDR_W'(BASE + SLOT_UE)) begin
                word[CNT_W-1:0] = ue_cnt[ch];
            end else if (reg_addr == ADDR_W'(BASE + SLOT_FLAG)) begin
                word[0] = flag[ch];
            end
        end

        assign ch_word[ch] = word;
        assign flag_rd[ch] = reg_rd && (reg_addr == ADDR_W'(BASE + SLOT_FLAG));
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            reg_rdata = cfg_word;
            for (int i = 0; i < NUM_CH; i++) begin
                reg_rdata = reg_rdata | ch_word[i];
            end
        end
    end

    AST_ONE_FLAG_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flag_rd)); // R7

    AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |-> (reg_rdata == '0)); // R7

endmodule

// File: rtl/ecc_err_stats.sv
module ecc_err_stats
    import ecc_stats_pkg::*;
#(
    parameter int unsigned NUM_CH = 2,
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ce_err,
    input  logic [NUM_CH-1:0] ue_err,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NUM_CH-1:0] thr_flag
);
    logic [NUM_CH-1:0][CNT_W-1:0] ce_cnt;
    logic [NUM_CH-1:0][CNT_W-1:0] ue_cnt;
    logic [NUM_CH-1:0]            flag_rd;
    logic                         clr;
    logic [CNT_W-1:0]             thresh;

    ecc_reg_file #(
        .NUM_CH (NUM_CH),
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .ce_cnt    (ce_cnt),
        .ue_cnt    (ue_cnt),
        .flag      (thr_flag),
        .clr       (clr),
        .thresh    (thresh),
        .flag_rd   (flag_rd),
        .reg_rdata (reg_rdata)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_trk
        ecc_chan_tracker #(.CNT_W(CNT_W)) u_trk (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (clr),
            .thresh  (thresh),
            .ce_err  (ce_err[ch]),
            .ue_err  (ue_err[ch]),
            .flag_rd (flag_rd[ch]),
            .ce_cnt  (ce_cnt[ch]),
            .ue_cnt  (ue_cnt[ch]),
            .flag    (thr_flag[ch])
        );
    end

    AST_RESET_CLEAN: assert property (@(posedge clk)
        !rst_n |=> (thr_flag == '0)); // R8

endmodule

// File: tb/ecc_err_stats_tb.sv
module ecc_err_stats_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ce_err = '0;
    logic [1:0]  ue_err = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  thr_flag;

    int checks = 0;
    int fails  = 0;

    localparam logic [7:0] A_CTRL = 8'h00, A_THR = 8'h04;
    localparam logic [7:0] A_CE0 = 8'h08, A_UE0 = 8'h0C, A_FL0 = 8'h10;
    localparam logic [7:0] A_CE1 = 8'h14, A_UE1 = 8'h18, A_FL1 = 8'h1C;

    always #2 clk = ~clk;

    ecc_err_stats u_dut (
        .clk(clk), .rst_n(rst_n), .ce_err(ce_err), .ue_err(ue_err),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .thr_flag(thr_flag)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic pulse(input logic [1:0] ce, input logic [1:0] ue, input int n);
        @(negedge clk);
        ce_err = ce; ue_err = ue;
        repeat (n) @(negedge clk);
        ce_err = '0; ue_err = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(A_CTRL, d); chk("R8 ctrl", d, 0);
        rd(A_THR, d);  chk("R8 thresh", d, 0);
        rd(A_CE0, d);  chk("R8 ce0", d, 0);
        rd(A_UE1, d);  chk("R8 ue1", d, 0);
        chk("R8 flags", {30'd0, thr_flag}, 0);
    endtask

    task automatic t_threshold();
        logic [31:0] d;
        wr(A_THR, 32'd3);
        pulse(2'b01, 2'b00, 3);
        rd(A_CE0, d); chk("R3 below thresh", d, 0);
        chk("R4 no flag yet", {30'd0, thr_flag}, 0);
        pulse(2'b01, 2'b00, 1);
        rd(A_CE0, d); chk("R3 first counted", d, 1);
        chk("R4 flag0 set", {30'd0, thr_flag}, 32'd1);
        rd(A_CE1, d); chk("R9 ch1 ce untouched", d, 0);
        rd(A_FL0, d); chk("R5 read returns flag", d, 1);
        chk("R5 read cleared", {30'd0, thr_flag}, 0);
        pulse(2'b01, 2'b00, 2);
        rd(A_CE0, d); chk("R3 k-N count", d, 3);
        chk("R4 flag reset by error", {30'd0, thr_flag}, 32'd1);
        rd(A_FL0, d);
    endtask

    task automatic t_uncorrectable();
        logic [31:0] d;
        pulse(2'b00, 2'b10, 5);
        rd(A_UE1, d); chk("R6 ue ignores thresh", d, 5);
        rd(A_UE0, d); chk("R9 ue0 untouched", d, 0);
        chk("R6 no flag from ue", {30'd0, thr_flag}, 0);
    endtask

    task automatic t_clear();
        logic [31:0] d;
        wr(A_CTRL, 32'd1);
        rd(A_CE0, d); chk("R2 ce0 zeroed", d, 0);
        pulse(2'b11, 2'b11, 10);
        rd(A_UE1, d); chk("R2 ue1 held", d, 0);
        rd(A_CE1, d); chk("R2 ce1 held", d, 0);
        wr(A_CTRL, 32'd0);
        pulse(2'b01, 2'b01, 1);
        rd(A_CE0, d); chk("R2 pre-count restarted", d, 0);
        rd(A_UE0, d); chk("R2 ue resumed", d, 1);
    endtask

    task automatic t_saturate();
        logic [31:0] d;
        wr(A_THR, 32'd0);
        wr(A_CTRL, 32'd1);
        wr(A_CTRL, 32'd0);
        pulse(2'b10, 2'b10, 300);
        rd(A_CE1, d); chk("R1 ce1 saturates", d, 255);
        rd(A_UE1, d); chk("R1 ue1 saturates", d, 255);
        rd(A_CE0, d); chk("R9 ce0 quiet", d, 0);
        rd(A_FL1, d);
    endtask

    task automatic t_race();
        logic [31:0] d;
        pulse(2'b01, 2'b00, 1);
        chk("R4 flag0 up", {30'd0, thr_flag}, 32'd1);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = A_FL0; ce_err = 2'b01;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0; ce_err = '0;
        chk("R5 race read value", d, 1);
        chk("R5 set wins", {30'd0, thr_flag}, 32'd1);
        rd(A_FL0, d);
        chk("R5 plain read clears", {30'd0, thr_flag}, 0);
    endtask

    task automatic t_map();
        logic [31:0] d;
        wr(A_CE1, 32'h0);
        rd(A_CE1, d); chk("R7 count write ignored", d, 255);
        wr(A_FL1, 32'h1);
        chk("R7 flag write ignored", {30'd0, thr_flag}, 0);
        wr(A_THR, 32'hFFFF_F1FF);
        rd(A_THR, d); chk("R7 upper bits zero", d, 32'hFF);
        rd(8'h40, d); chk("R7 unmapped zero", d, 0);
        wr(A_CTRL, 32'hFFFF_FFFE);
        rd(A_CTRL, d); chk("R7 ctrl bit0 only", d, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog got=timeout exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_threshold();
        t_uncorrectable();
        t_clear();
        t_saturate();
        t_race();
        t_map();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule